// File: doc/BRIEF.md
# Fractional clock rate controller

This block derives a clock-enable stream from its parent clock. Out of every 32 parent cycles it lets through a programmable number of enable pulses, so a downstream gated domain runs at a fraction of the parent rate. Software programs a 5-bit rate field and then requests the change with a kick bit. The new rate takes effect only at a frame boundary after a short fixed settling time, and the kick bit clears itself once the new rate is in force.

The field encodes how many pulses are removed, so the pulse count per frame is 32 minus the field value. A field of 0 gives the full parent rate and a field of 31 gives one pulse per frame. Inside a frame an accumulator spreads the pulses as evenly as it can. A count port and a one-cycle frame marker let a consumer confirm the rate actually in effect.

Top module: `frac_rate_ctrl`

## Requirements
- R1: After a completed change, every 32-cycle frame carries exactly 32 minus F enable pulses on `rate_en_o`, where F is bits 12:8 of the frequency register (word address 0).
- R2: A field of 0 gives an enable on every parent cycle (32 per frame) and a field of 31 gives a single enable per frame.
- R3: The frequency register reads back all 32 written bits. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R4: Writing a word with bit 31 set to the control register (word address 1) while idle makes bit 31 of that register read 1. A changed field has no effect on the pulse rate until such a kick.
- R5: The kick bit clears itself only at the end of a frame, no earlier than 8 parent cycles after the kick and no later than 8 + 32 + 3 cycles after it. The new rate holds from the following frame on.
- R6: While the kick bit reads 1, writes to the frequency register leave bits 12:8 unchanged but still update every other bit.
- R7: A kick written while a change is pending is ignored, and writing 0 to bit 31 has no effect.
- R8: Within a steady rate, the gaps between consecutive enables differ from each other by at most one cycle.
- R9: After reset the frequency register and the control register read 0 and the output runs at full rate.
- R10: `frame_done_o` pulses for one cycle every 32 cycles. In that cycle `frame_pulses_o` holds the number of enables in the frame just ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address: 0 frequency register, 1 control register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rate_en_o | output | 1 | Registered clock-enable pulse stream |
| frame_pulses_o | output | 6 | Enable count of the last completed frame |
| frame_done_o | output | 1 | One-cycle marker that `frame_pulses_o` was updated |

## Verification
The bench builds the block with its defaults: a 5-bit field, which gives a 32-cycle frame, and a settling time of 8 cycles. A rate change therefore completes within a few dozen cycles. This lets the bench sweep both field extremes, a set of seeded random fields, and the pending-state cases where field writes and repeated kicks arrive during a change. For each rate it checks the per-frame pulse count and the gap spread.

// File: rtl/frc_pkg.sv
package frc_pkg;
  // word addresses of the two registers
  localparam int unsigned REG_FREQ = 0;
  localparam int unsigned REG_CTRL = 1;
endpackage

// File: rtl/frc_regs.sv
module frc_regs #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned FIELD_W   = 5,
  parameter int unsigned KICK_BIT  = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               apply_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [FIELD_W-1:0] field_o,
  output logic               busy_o,
  output logic               kick_o
);
  import frc_pkg::*;

  localparam int unsigned FIELD_MSB = FIELD_LSB + FIELD_W - 1;
  localparam logic [DATA_W-1:0] FIELD_MASK =
    {{(DATA_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << FIELD_LSB;

  logic [DATA_W-1:0] freq_q;
  logic              busy_q;
  logic              sel_freq, sel_ctrl;
  logic [DATA_W-1:0] ctrl_word;

  assign sel_freq = (addr_i == ADDR_W'(REG_FREQ));
  assign sel_ctrl = (addr_i == ADDR_W'(REG_CTRL));
  assign kick_o   = wr_i && sel_ctrl && wdata_i[KICK_BIT] && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= '0;
    end else if (wr_i && sel_freq) begin
      if (busy_q)
        freq_q <= (wdata_i & ~FIELD_MASK) | (freq_q & FIELD_MASK);
      else
        freq_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      busy_q <= 1'b0;
    else if (kick_o)
      busy_q <= 1'b1;
    else if (apply_i)
      busy_q <= 1'b0;
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[KICK_BIT] = busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      if (sel_freq)      rdata_o <= freq_q;
      else if (sel_ctrl) rdata_o <= ctrl_word;
      else               rdata_o <= '0;
    end
  end

  assign field_o = freq_q[FIELD_MSB:FIELD_LSB];
  assign busy_o  = busy_q;
endmodule

// File: rtl/frc_sequencer.sv
module frc_sequencer #(
  parameter int unsigned FRAME  = 32,
  parameter int unsigned SETTLE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  input  logic busy_i,
  output logic frame_last_o,
  output logic apply_o
);
  localparam int unsigned POS_W = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam int unsigned SET_W = $clog2(SETTLE + 1);

  logic [POS_W-1:0] pos_q;
  logic [SET_W-1:0] settle_q;

  assign frame_last_o = (pos_q == POS_W'(FRAME - 1));

  always_ff @(posedge clk) begin
    if (rst)               pos_q <= '0;
    else if (frame_last_o) pos_q <= '0;
    else                   pos_q <= pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  settle_q <= '0;
    else if (kick_i)          settle_q <= SET_W'(SETTLE);
    else if (settle_q != '0)  settle_q <= settle_q - 1'b1;
  end

  assign apply_o = busy_i && (settle_q == '0) && frame_last_o;
endmodule

// File: rtl/frc_pulse_gen.sv
module frc_pulse_gen #(
  parameter int unsigned FIELD_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               apply_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               frame_last_i,
  output logic               en_o,
  output logic [FIELD_W:0]   count_o,
  output logic               mark_o,
  output logic [FIELD_W:0]   mult_o
);
  localparam int unsigned FRAME  = 1 << FIELD_W;
  localparam int unsigned MULT_W = FIELD_W + 1;
  localparam int unsigned ACC_W  = FIELD_W + 2;

  logic [MULT_W-1:0] mult_q;
  logic [ACC_W-1:0]  acc_q, sum;
  logic              wrap;
  logic [MULT_W-1:0] run_q, run_next;

  always_ff @(posedge clk) begin
    if (rst)          mult_q <= MULT_W'(FRAME);
    else if (apply_i) mult_q <= MULT_W'(FRAME) - MULT_W'(field_i);
  end

  assign sum      = acc_q + ACC_W'(mult_q);
  assign wrap     = (sum >= ACC_W'(FRAME));
  assign run_next = run_q + MULT_W'(wrap);

  always_ff @(posedge clk) begin
    if (rst)               acc_q <= '0;
    else if (frame_last_i) acc_q <= '0;
    else if (wrap)         acc_q <= sum - ACC_W'(FRAME);
    else                   acc_q <= sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o    <= 1'b0;
      run_q   <= '0;
      count_o <= '0;
      mark_o  <= 1'b0;
    end else begin
      en_o <= wrap;
      if (frame_last_i) begin
        count_o <= run_next;
        run_q   <= '0;
        mark_o  <= 1'b1;
      end else begin
        run_q  <= run_next;
        mark_o <= 1'b0;
      end
    end
  end

  assign mult_o = mult_q;
endmodule

// File: rtl/frac_rate_ctrl.sv
module frac_rate_ctrl #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned FIELD_W   = 5,
  parameter int unsigned KICK_BIT  = 31,
  parameter int unsigned SETTLE    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rate_en_o,
  output logic [FIELD_W:0]  frame_pulses_o,
  output logic              frame_done_o
);
  localparam int unsigned FRAME = 1 << FIELD_W;

  logic [FIELD_W-1:0] field;
  logic               busy, kick, apply, frame_last;
  logic [FIELD_W:0]   mult;

  frc_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_LSB(FIELD_LSB),
    .FIELD_W(FIELD_W), .KICK_BIT(KICK_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .apply_i(apply), .rdata_o(bus_rdata),
    .field_o(field), .busy_o(busy), .kick_o(kick)
  );

  frc_sequencer #(.FRAME(FRAME), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst(rst), .kick_i(kick), .busy_i(busy),
    .frame_last_o(frame_last), .apply_o(apply)
  );

  frc_pulse_gen #(.FIELD_W(FIELD_W)) u_gen (
    .clk(clk), .rst(rst), .apply_i(apply), .field_i(field),
    .frame_last_i(frame_last), .en_o(rate_en_o), .count_o(frame_pulses_o),
    .mark_o(frame_done_o), .mult_o(mult)
  );
endmodule

// File: rtl/frac_rate_ctrl_chk.sv
module frac_rate_ctrl_chk #(
  parameter int unsigned FIELD_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic [FIELD_W-1:0] field,
  input logic               frame_last,
  input logic [FIELD_W:0]   mult,
  input logic [FIELD_W:0]   frame_pulses,
  input logic               frame_done
);
  localparam int unsigned FRAME = 1 << FIELD_W;

  // R5
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(frame_last));

  // R6
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(field));

  // R10
  frame_count_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (frame_pulses == $past(mult)));

  // R1
  mult_range_chk: assert property (@(posedge clk) disable iff (rst)
    (mult >= 1) && (mult <= (FIELD_W+1)'(FRAME)));

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && field == '0 && mult == (FIELD_W+1)'(FRAME)));
endmodule

bind frac_rate_ctrl frac_rate_ctrl_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .field(field), .frame_last(frame_last),
  .mult(mult), .frame_pulses(frame_pulses_o), .frame_done(frame_done_o)
);

// File: tb/frac_rate_ctrl_test.sv
module frac_rate_ctrl_test;
  localparam int FW = 5;
  localparam int FRAME = 32;
  localparam int SETTLE = 8;

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        rate_en_o;
  logic [FW:0] frame_pulses_o;
  logic        frame_done_o;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit timed_out = 0;

  bit gap_on = 0;
  int last_en = -1, gmin = 1000, gmax = 0;

  frac_rate_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rate_en_o(rate_en_o), .frame_pulses_o(frame_pulses_o),
    .frame_done_o(frame_done_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (gap_on && rate_en_o) begin
      if (last_en >= 0) begin
        if (cyc - last_en < gmin) gmin = cyc - last_en;
        if (cyc - last_en > gmax) gmax = cyc - last_en;
      end
      last_en = cyc;
    end
  end

  function automatic int exp_pulses(input int f);
    return FRAME - f;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1; bus_addr = 2'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1; bus_addr = 2'(a);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic wait_mark();
    do @(negedge clk); while (!frame_done_o);
  endtask

  // kick and poll until the change completes; returns latency
  task automatic kick_and_wait(output int lat);
    logic [31:0] d;
    int t0;
    t0 = cyc;
    wr(1, 32'h8000_0000);
    rd(1, d);
    check("R4 busy after kick", int'(d[31]), 1);
    while (d[31]) rd(1, d);
    lat = cyc - t0;
  endtask

  task automatic measure_frame(input string req, input int f);
    wait_mark(); wait_mark();
    check(req, int'(frame_pulses_o), exp_pulses(f));
  endtask

  task automatic measure_gaps(input int f);
    last_en = -1; gmin = 1000; gmax = 0; gap_on = 1;
    wait_mark(); wait_mark(); wait_mark();
    gap_on = 0;
    if (exp_pulses(f) > 1) check("R8 gap spread", gmax - gmin <= 1 ? 1 : 0, 1);
    else check("R8 single pulse gap", gmax, FRAME);
  endtask

  task automatic run_rate(input int f, input string req);
    logic [31:0] v;
    int lat;
    v = $urandom();
    v[12:8] = 5'(f);
    wr(0, v);
    kick_and_wait(lat);
    check("R5 latency lower", lat >= SETTLE ? 1 : 0, 1);
    check("R5 latency upper", lat <= SETTLE + FRAME + 3 ? 1 : 0, 1);
    measure_frame(req, f);
    measure_gaps(f);
  endtask

  task automatic main();
    logic [31:0] d, v;
    int t0, lat;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    rd(0, d); check("R9 freq reset", int'(d), 0);
    rd(1, d); check("R9 ctrl reset", int'(d), 0);
    wait_mark(); check("R9 full rate", int'(frame_pulses_o), FRAME);
    // R10 marker spacing
    t0 = cyc; wait_mark();
    check("R10 mark spacing", cyc - t0, FRAME);
    // R3 readback
    v = 32'hA5C3_1F69;
    wr(0, v); rd(0, d); check("R3 readback", int'(d), int'(v));
    // R4 no effect without kick (field 0x1F written above)
    wait_mark(); wait_mark();
    check("R4 no kick no change", int'(frame_pulses_o), FRAME);
    // R7 writing zero to kick
    wr(1, 32'h7FFF_FFFF); rd(1, d);
    check("R7 zero kick ignored", int'(d[31]), 0);
    // R2 extremes
    run_rate(31, "R2 slowest rate");
    run_rate(0, "R2 full rate");
    run_rate(1, "R1 rate f=1");
    run_rate(16, "R1 rate f=16");
    for (int i = 0; i < 6; i++) run_rate(int'($urandom() % 32), "R1 random rate");
    // R6 field write while busy
    v = 32'h0000_0300;
    wr(0, v);
    wr(1, 32'h8000_0000);
    wr(0, 32'h1234_1E78);
    rd(0, d);
    check("R6 field held", int'(d[12:8]), 3);
    check("R6 other bits written", int'(d & 32'hFFFF_E0FF), int'(32'h1234_0078));
    // R7 kick while busy
    wr(1, 32'h8000_0000);
    rd(1, d);
    check("R7 busy kept", int'(d[31]), 1);
    while (d[31]) rd(1, d);
    measure_frame("R6 R7 rate after pending writes", 3);
    // R5 latency bound again, measured from an idle kick
    v[12:8] = 5'd20; wr(0, v);
    kick_and_wait(lat);
    check("R5 latency upper f=20", lat <= SETTLE + FRAME + 3 ? 1 : 0, 1);
    measure_frame("R1 rate f=20", 20);
  endtask

  initial begin
    fork
      main();
      begin repeat (150000) @(posedge clk); timed_out = 1; end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule